// File: doc/BRIEF.md
# Triple Match Timer Unit

Three independent counters share a single APB-style register window. Each timer owns a counter, a reload value and two compare values. It steps up or down by one. It steps on every bus clock or only on cycles where an external tick-enable input is high. When it runs past its end value it reloads and continues. Comparing each newly stepped counter value against the two compare values, together with the wrap event, produces sticky status flags. Each flag can be masked individually, and the unmasked flags are ORed into one interrupt line.

Control and status are packed three bits per timer in shared words, so software can service all timers with one read. The direction bits sit in a separate field above the packed triplets. Writes complete in one access phase, and reads return combinationally from the word address.

Top module: `tri_match_timer`

## Requirements
- R1: Timer n (1..3) has read/write words at byte offset (n-1)*0x10: counter +0x0, reload +0x4, compare A +0x8, compare B +0xC. The control word is at 0x30, the flag word at 0x34 and the mask word at 0x38. All of them reset to zero. Unmapped offsets read zero.
- R2: In the control word, timer n uses bit 3(n-1) for run, bit 3(n-1)+1 for tick select and bit 3(n-1)+2 for wrap-flag enable. Bit 9+(n-1) selects direction.
- R3: With direction 1, each step adds one. A step taken while the counter is all ones loads the reload value instead.
- R4: With direction 0, each step subtracts one. A step taken while the counter is zero loads the reload value instead.
- R5: With the run bit 0, the counter holds its value whatever tick_en does.
- R6: With tick select 0 the timer steps on every clock edge. With tick select 1 it steps only on edges where tick_en is high.
- R7: Flag bit 3(n-1) (compare A) or 3(n-1)+1 (compare B) is set by the step that makes the counter equal that compare value. The flag becomes visible in the same cycle as the new counter value.
- R8: Flag bit 3(n-1)+2 is set by a reloading step only when the wrap-flag enable bit is 1. The reload itself happens regardless of that bit.
- R9: Writing the flag word clears each bit written as 1 and leaves bits written as 0. An event in the same cycle as its clear leaves the bit set.
- R10: The mask word has the flag word's layout. irq is high exactly when some flag is set and its mask bit is 0.
- R11: A bus write to a counter takes the place of that cycle's step and sets no flag.
- R12: Control bits 31:12 and flag/mask bits 31:9 ignore writes and read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | External step qualifier for timers in tick mode |
| psel | input | 1 | Access select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | Write when high |
| paddr | input | AW (8) | Byte address |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data for paddr |
| irq | output | 1 | OR of unmasked flags |

## Verification
The hardest situation to create from the ports is a flag clear landing on the same edge as the event that sets that flag. The bench puts the timer in tick mode and raises tick_en only during the access phase of the clearing write, so exactly one step coincides with the clear. The same free-running timers make it hard to know where the counter stands when it is read. For that reason, most scenarios advance the counter with single tick pulses. The one free-running case is bracketed by two back-to-back control writes whose capture edges are a known three cycles apart.

// File: rtl/tri_match_timer.sv
module tri_match_timer #(
  parameter int NT = 3,
  parameter int CW = 32,
  parameter int AW = 8
)(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [31:0]   pwdata,
  output logic [31:0]   prdata,
  output logic          irq
);
  localparam int FW  = 3 * NT;
  localparam int CTW = 4 * NT;
  localparam int WIX = AW - 2;
  localparam logic [WIX-1:0] A_CTRL  = WIX'(4 * NT);
  localparam logic [WIX-1:0] A_STATE = WIX'(4 * NT + 1);
  localparam logic [WIX-1:0] A_MASK  = WIX'(4 * NT + 2);

  logic [CW-1:0]  cnt [NT];
  logic [CW-1:0]  ld  [NT];
  logic [CW-1:0]  m1  [NT];
  logic [CW-1:0]  m2  [NT];
  logic [CTW-1:0] ctrl;
  logic [FW-1:0]  ist, imask, evt;
  logic [31:0]    rd;
  logic           unused_bits;

  wire           wr   = psel & penable & pwrite;
  wire [WIX-1:0] widx = paddr[AW-1:2];

  assign unused_bits = ^{paddr[1:0], pwdata};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl  <= '0;
      imask <= '0;
      ist   <= '0;
    end else begin
      if (wr && widx == A_CTRL) ctrl  <= pwdata[CTW-1:0];
      if (wr && widx == A_MASK) imask <= pwdata[FW-1:0];
      ist <= (ist & ~((wr && widx == A_STATE) ? pwdata[FW-1:0] : '0)) | evt;
    end
  end

  for (genvar i = 0; i < NT; i++) begin : g_tmr
    localparam logic [WIX-1:0] A_CNT = WIX'(4 * i);
    localparam logic [WIX-1:0] A_LD  = WIX'(4 * i + 1);
    localparam logic [WIX-1:0] A_M1  = WIX'(4 * i + 2);
    localparam logic [WIX-1:0] A_M2  = WIX'(4 * i + 3);

    wire run  = ctrl[3*i];
    wire csel = ctrl[3*i+1];
    wire ovfe = ctrl[3*i+2];
    wire up   = ctrl[FW+i];
    wire wr_c = wr && widx == A_CNT;
    wire adv  = run & (~csel | tick_en) & ~wr_c;
    wire lim  = up ? (&cnt[i]) : (cnt[i] == '0);
    wire [CW-1:0] nxt = lim ? ld[i] : (up ? cnt[i] + CW'(1) : cnt[i] - CW'(1));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt[i] <= '0;
        ld[i]  <= '0;
        m1[i]  <= '0;
        m2[i]  <= '0;
      end else begin
        if (wr_c)     cnt[i] <= pwdata[CW-1:0];
        else if (adv) cnt[i] <= nxt;
        if (wr && widx == A_LD) ld[i] <= pwdata[CW-1:0];
        if (wr && widx == A_M1) m1[i] <= pwdata[CW-1:0];
        if (wr && widx == A_M2) m2[i] <= pwdata[CW-1:0];
      end
    end

    assign evt[3*i]   = adv && nxt == m1[i];
    assign evt[3*i+1] = adv && nxt == m2[i];
    assign evt[3*i+2] = adv && lim && ovfe;
  end

  always_comb begin
    rd = '0;
    for (int t = 0; t < NT; t++) begin
      if (widx == WIX'(4 * t))     rd = 32'(cnt[t]);
      if (widx == WIX'(4 * t + 1)) rd = 32'(ld[t]);
      if (widx == WIX'(4 * t + 2)) rd = 32'(m1[t]);
      if (widx == WIX'(4 * t + 3)) rd = 32'(m2[t]);
    end
    if (widx == A_CTRL)  rd = 32'(ctrl);
    if (widx == A_STATE) rd = 32'(ist);
    if (widx == A_MASK)  rd = 32'(imask);
  end

  assign prdata = rd;
  assign irq    = |(ist & ~imask);
endmodule

// File: rtl/tri_match_timer_chk.sv
module tri_match_timer_chk #(
  parameter int NT = 3,
  parameter int CW = 32,
  parameter int AW = 8
)(
  input logic            clk,
  input logic            rst_n,
  input logic            psel,
  input logic            penable,
  input logic            pwrite,
  input logic [AW-1:0]   paddr,
  input logic [31:0]     prdata,
  input logic            irq,
  input logic [4*NT-1:0] ctrl,
  input logic [3*NT-1:0] ist,
  input logic [3*NT-1:0] imask,
  input logic [CW-1:0]   cnt0
);
  localparam int WIX = AW - 2;
  wire [WIX-1:0] widx = paddr[AW-1:2];
  wire wr       = psel & penable & pwrite;
  wire wr_state = wr && widx == WIX'(4 * NT + 1);
  wire wr_cnt0  = wr && widx == WIX'(0);

  AST_FLAG_CLEAR_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(ist) & ~ist)) |-> $past(wr_state)); // R9
  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (&imask) |-> !irq); // R10
  AST_CTRL_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (widx == WIX'(4 * NT)) |-> (prdata[31:4*NT] == '0)); // R12
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl[0] && !wr_cnt0) |=> $stable(cnt0)); // R5
  AST_MATCH_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ist[0]) |-> $past(ctrl[0])); // R7

  for (genvar i = 0; i < NT; i++) begin : g_ovf
    AST_WRAP_FLAG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ist[3*i+2]) |-> $past(ctrl[3*i+2])); // R8
  end
endmodule

bind tri_match_timer tri_match_timer_chk #(.NT(NT), .CW(CW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .prdata(prdata), .irq(irq), .ctrl(ctrl), .ist(ist),
  .imask(imask), .cnt0(cnt[0])
);

// File: tb/tb_tri_match_timer.sv
`timescale 1ns/1ps
module tb_tri_match_timer;
  logic clk = 0, rst_n = 0, tick_en = 0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [7:0] paddr = 0;
  logic [31:0] pwdata = 0, prdata;
  logic irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tri_match_timer dut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq(irq));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, logic tk = 1'b0);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; tick_en = tk;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0; tick_en = 0;
  endtask

  task automatic rchk(string req, logic [7:0] a, logic [31:0] exp);
    @(negedge clk); paddr = a; #1;
    chk(req, prdata, exp);
  endtask

  task automatic ichk(string req, logic exp);
    @(negedge clk); #1;
    chk(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic tick();
    @(negedge clk); tick_en = 1;
    @(negedge clk); tick_en = 0;
  endtask

  task automatic t_reset();
    for (int a = 0; a < 16; a++) rchk("R1 reset", 8'(a * 4), 0);
    ichk("R10 reset irq", 0);
  endtask

  task automatic t_map();
    for (int t = 0; t < 3; t++)
      for (int k = 0; k < 4; k++) wr(8'(t * 16 + k * 4), 32'hA000_0000 | (t << 8) | k);
    for (int t = 0; t < 3; t++)
      for (int k = 0; k < 4; k++) rchk("R1 readback", 8'(t * 16 + k * 4), 32'hA000_0000 | (t << 8) | k);
    rchk("R1 unmapped", 8'h3C, 0);
    wr(8'h30, 32'hFFFF_FFFF); rchk("R12 ctrl rsvd", 8'h30, 32'h0000_0FFF);
    wr(8'h30, 0);
    wr(8'h34, 32'hFFFF_FFFF); rchk("R12 state", 8'h34, 0);
    wr(8'h38, 32'hFFFF_FFFF); rchk("R12 mask rsvd", 8'h38, 32'h0000_01FF);
    wr(8'h38, 0);
  endtask

  task automatic t_up_wrap();
    wr(8'h00, 32'hFFFF_FFFD); wr(8'h04, 5); wr(8'h08, 32'hFFFF_FFFF); wr(8'h0C, 6);
    wr(8'h30, 32'h207);
    tick(); rchk("R3 up step", 8'h00, 32'hFFFF_FFFE); rchk("R7 no flag yet", 8'h34, 0);
    tick(); rchk("R3 all ones", 8'h00, 32'hFFFF_FFFF); rchk("R7 compare A", 8'h34, 32'h1);
    ichk("R10 irq on flag", 1);
    tick(); rchk("R3 reload", 8'h00, 5); rchk("R8 wrap flag", 8'h34, 32'h5);
    tick(); rchk("R3 after reload", 8'h00, 6); rchk("R7 compare B", 8'h34, 32'h7);
  endtask

  task automatic t_down();
    wr(8'h30, 0);
    wr(8'h34, 32'h1FF); rchk("R9 clear all", 8'h34, 0);
    wr(8'h10, 1); wr(8'h14, 32'h100); wr(8'h18, 0); wr(8'h1C, 32'hFF);
    wr(8'h30, 32'h18);
    tick(); rchk("R4 down step", 8'h10, 0); rchk("R7 timer2 A", 8'h34, 32'h08);
    tick(); rchk("R4 reload", 8'h10, 32'h100); rchk("R8 no wrap flag", 8'h34, 32'h08);
    tick(); rchk("R4 after reload", 8'h10, 32'hFF); rchk("R7 timer2 B", 8'h34, 32'h18);
  endtask

  task automatic t_w1c();
    wr(8'h34, 32'h08); rchk("R9 partial clear", 8'h34, 32'h10);
    wr(8'h34, 0); rchk("R9 zero write", 8'h34, 32'h10);
    wr(8'h38, 32'h10); ichk("R10 masked", 0);
    wr(8'h38, 0); ichk("R10 unmasked", 1);
    wr(8'h34, 32'h1FF); ichk("R10 cleared", 0);
    wr(8'h30, 0);
    wr(8'h20, 9); wr(8'h28, 10); wr(8'h2C, 32'hFFFF);
    wr(8'h30, 32'h8C0);
    wr(8'h34, 32'h40, 1'b1);
    rchk("R9 event beats clear", 8'h34, 32'h40);
    rchk("R6 tick step", 8'h20, 10);
    wr(8'h30, 0); wr(8'h34, 32'h1FF);
  endtask

  task automatic t_hold();
    wr(8'h00, 100);
    wr(8'h30, 32'h202);
    tick(); tick(); tick();
    rchk("R5 stopped", 8'h00, 100);
    wr(8'h30, 32'h203);
    repeat (5) @(negedge clk);
    rchk("R6 no tick", 8'h00, 100);
    wr(8'h30, 32'h201); wr(8'h30, 0);
    rchk("R6 every clock", 8'h00, 103);
    rchk("R7 no false match", 8'h34, 0);
  endtask

  task automatic t_bus_prio();
    wr(8'h10, 32'h50); wr(8'h18, 0); wr(8'h1C, 32'h1234);
    wr(8'h30, 32'h8);
    wr(8'h10, 32'h1234); wr(8'h30, 0);
    rchk("R11 write wins", 8'h10, 32'h1231);
    rchk("R11 no flag", 8'h34, 0);
    rchk("R2 ctrl off", 8'h30, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_map();
    t_up_wrap();
    t_down();
    t_w1c();
    t_hold();
    t_bus_prio();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule